// File: doc/BRIEF.md
# Lockable Low-Power Entry Gate

This block sits between a processor core and the device's power controller and decides whether a stop or wait request from the core may turn into actual entry into the matching low-power mode. Each mode owns a 2-bit disable field in one control register reached over a simple bus made of a write enable, an address, write data and combinational read data.

When the core raises a stop or wait request, the block raises the matching entry output in that same cycle only if the field for that mode permits it. Software may block a mode temporarily, or block it and freeze its field so that no later write can re-enable the mode until the device is reset. The reset input is asynchronous and active low; its release is synchronised internally, so the fields stay cleared for two clock edges after the input rises.

Top module: `lpm_entry_gate`

## Requirements
- R1: After any reset both fields hold 00 and a read of the control address returns 0x0000.
- R2: With a field at 00, a request for that mode raises its entry output in the same cycle as the request.
- R3: With a field at 01, requests for that mode never raise its entry output, and a later write may still change the field to any value.
- R4: With a field at 10 or 11 (upper field bit set), requests for that mode never raise its entry output and every later write leaves the field unchanged.
- R5: The wait field is bits 1:0 and the stop field is bits 3:2 of the control register; all other bits read as 0 and writing them has no visible effect.
- R6: A frozen field does not stop writes to the other field, which still follows its own rules.
- R7: A write to any address other than the control address changes neither field, and a read of any other address returns 0.
- R8: An entry output is high only in a cycle where the matching request is high; a request in the same cycle as a write is judged against the field value held before that write.
- R9: A reset returns a frozen field to 00 so that the mode can be entered again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed register, combinational |
| wait_req | input | 1 | Core asks to enter wait mode |
| stop_req | input | 1 | Core asks to enter stop mode |
| wait_enter | output | 1 | Wait mode entry granted this cycle |
| stop_enter | output | 1 | Stop mode entry granted this cycle |

## Verification
A wrong field value appears at the ports in the very next cycle: a read of the control address shows it directly, and a request in that cycle grants or refuses entry the wrong way. The sweep therefore writes every pair of 4-bit register values in sequence from reset, reads back after each write and fires both requests, so a lock that fails to hold, a lock that engages on the wrong encoding, or a field wired to the wrong bits is seen within one cycle of the write that exposes it.

// File: rtl/lpm_gate_pkg.sv
package lpm_gate_pkg;

  localparam int FIELD_W   = 2;
  localparam int NUM_MODES = 2;

  // Mode index doubles as field position: wait in the low slot, stop above.
  localparam int MODE_WAIT = 0;
  localparam int MODE_STOP = 1;

  typedef enum logic [FIELD_W-1:0] {
    GATE_OPEN    = 2'b00,
    GATE_SHUT    = 2'b01,
    GATE_FROZEN  = 2'b10,
    GATE_FROZEN2 = 2'b11
  } gate_code_e;

endpackage

// File: rtl/lpm_rst_sync.sv
module lpm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/lpm_mode_field.sv
module lpm_mode_field
  import lpm_gate_pkg::*;
(
  input  logic               clk,
  input  logic               arst_n,
  input  logic               wr_hit,
  input  logic [FIELD_W-1:0] wr_val,
  input  logic               req,
  output logic [FIELD_W-1:0] field_q,
  output logic               enter
);

  logic               frozen;
  logic               upd_en;
  logic [FIELD_W-1:0] field_d;

  // Upper bit set means the field refuses every write until reset.
  assign frozen = field_q[FIELD_W-1];

  always_comb begin
    upd_en  = wr_hit && !frozen;
    field_d = field_q;
    if (upd_en) field_d = wr_val;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     field_q <= GATE_OPEN;
    else if (upd_en) field_q <= field_d;
  end

  // Grant uses the registered value, so a same-cycle write does not count.
  assign enter = req && (field_q == GATE_OPEN);

endmodule

// File: rtl/lpm_entry_gate.sv
module lpm_entry_gate
  import lpm_gate_pkg::*;
#(
  parameter int              ADDR_W    = 4,
  parameter int              DATA_W    = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              wait_req,
  input  logic              stop_req,
  output logic              wait_enter,
  output logic              stop_enter
);

  localparam int USED_W = NUM_MODES * FIELD_W;

  logic                                rst_ln;
  logic                                ctrl_sel;
  logic                                ctrl_wr;
  logic [NUM_MODES-1:0]                req_vec;
  logic [NUM_MODES-1:0]                enter_vec;
  logic [NUM_MODES-1:0][FIELD_W-1:0]   field_q;
  logic [DATA_W-1:0]                   rdata_d;
  logic                                unused_upper;

  lpm_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ln)
  );

  assign ctrl_sel = (bus_addr == CTRL_ADDR);
  assign ctrl_wr  = bus_we && ctrl_sel;

  assign req_vec[MODE_WAIT] = wait_req;
  assign req_vec[MODE_STOP] = stop_req;

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_mode
    lpm_mode_field u_field (
      .clk     (clk),
      .arst_n  (rst_ln),
      .wr_hit  (ctrl_wr),
      .wr_val  (bus_wdata[g*FIELD_W +: FIELD_W]),
      .req     (req_vec[g]),
      .field_q (field_q[g]),
      .enter   (enter_vec[g])
    );
  end

  assign wait_enter = enter_vec[MODE_WAIT];
  assign stop_enter = enter_vec[MODE_STOP];

  always_comb begin
    rdata_d = '0;
    if (ctrl_sel) rdata_d[USED_W-1:0] = field_q;
  end

  assign bus_rdata    = rdata_d;
  assign unused_upper = ^bus_wdata[DATA_W-1:USED_W];

endmodule

// File: rtl/lpm_entry_gate_chk.sv
module lpm_entry_gate_chk
  import lpm_gate_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_ln,
  input logic              ctrl_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [1:0]        wait_f,
  input logic [1:0]        stop_f,
  input logic              wait_req,
  input logic              stop_req,
  input logic              wait_enter,
  input logic              stop_enter
);

  // R4
  wait_frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    wait_f[1] |=> $stable(wait_f));
  // R4
  stop_frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    stop_f[1] |=> $stable(stop_f));
  // R3
  wait_rewrite_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    (ctrl_wr && !wait_f[1]) |=> (wait_f == $past(bus_wdata[1:0])));
  // R6
  stop_rewrite_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    (ctrl_wr && !stop_f[1]) |=> (stop_f == $past(bus_wdata[3:2])));
  // R8
  wait_grant_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    wait_enter |-> (wait_req && wait_f == 2'b00));
  // R8
  stop_grant_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    stop_enter |-> (stop_req && stop_f == 2'b00));
  // R2
  wait_open_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    (wait_req && wait_f == 2'b00) |-> wait_enter);
  // R5
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    bus_rdata[DATA_W-1:4] == '0);

endmodule

bind lpm_entry_gate lpm_entry_gate_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_ln     (rst_ln),
  .ctrl_wr    (ctrl_wr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .wait_f     (field_q[0]),
  .stop_f     (field_q[1]),
  .wait_req   (wait_req),
  .stop_req   (stop_req),
  .wait_enter (wait_enter),
  .stop_enter (stop_enter)
);

// File: tb/lpm_entry_gate_bench.sv
`timescale 1ns/1ps
module lpm_entry_gate_bench;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_we;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata;
  logic              wait_req, stop_req;
  logic              wait_enter, stop_enter;

  int n_run  = 0;
  int n_fail = 0;
  logic [1:0] m_wait, m_stop;

  always #10 clk = ~clk;

  lpm_entry_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lpm_entry_gate (
    .clk, .rst_n, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .wait_req, .stop_req, .wait_enter, .stop_enter
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    wait_req = 1'b0; stop_req = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_wait = 2'b00; m_stop = 2'b00;
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = '0;
    if (a == '0) begin
      if (!m_wait[1]) m_wait = d[1:0];
      if (!m_stop[1]) m_stop = d[3:2];
    end
  endtask

  // Read back and probe both requests; outputs are combinational so sample mid-cycle.
  task automatic probe(input string tag);
    @(negedge clk);
    bus_addr = '0; #2;
    check({tag, " R5 readback"}, 32'(bus_rdata), 32'({m_stop, m_wait}));
    wait_req = 1'b1; stop_req = 1'b0; #2;
    check({tag, " R2/R3/R4 wait"}, 32'(wait_enter), 32'(m_wait == 2'b00));
    check({tag, " R8 stop idle"}, 32'(stop_enter), 32'd0);
    wait_req = 1'b0; stop_req = 1'b1; #2;
    check({tag, " R2/R3/R4 stop"}, 32'(stop_enter), 32'(m_stop == 2'b00));
    check({tag, " R8 wait idle"}, 32'(wait_enter), 32'd0);
    stop_req = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    wait_req = 1'b0; stop_req = 1'b0;

    // R1: reset state
    do_reset();
    #2;
    check("R1 rdata after reset", 32'(bus_rdata), 32'd0);
    probe("R1");

    // R3 R4 R6: exhaustive pairs of register values written in sequence
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        do_reset();
        do_write('0, DATA_W'(a) | 16'hA5F0);
        probe("R3_R4 first");
        do_write('0, DATA_W'(b) | 16'h5A00);
        probe("R4_R6 second");
      end
    end

    // R7: other address writes ignored and reads zero
    do_reset();
    do_write('0, 16'h0005);
    for (int k = 1; k < 16; k++) begin
      do_write(ADDR_W'(k), 16'hFFFA);
      @(negedge clk); bus_addr = ADDR_W'(k); #2;
      check("R7 other address reads 0", 32'(bus_rdata), 32'd0);
    end
    probe("R7 fields kept");

    // R8: request in the cycle of a write sees the old value
    do_reset();
    @(negedge clk);
    bus_we = 1'b1; bus_addr = '0; bus_wdata = 16'h0005; wait_req = 1'b1; stop_req = 1'b1; #2;
    check("R8 wait judged on old value", 32'(wait_enter), 32'd1);
    check("R8 stop judged on old value", 32'(stop_enter), 32'd1);
    @(negedge clk);
    bus_we = 1'b0; #2;
    check("R8 wait after write", 32'(wait_enter), 32'd0);
    check("R8 stop after write", 32'(stop_enter), 32'd0);
    wait_req = 1'b0; stop_req = 1'b0;
    m_wait = 2'b01; m_stop = 2'b01;

    // R9: reset clears a frozen field
    do_write('0, 16'h000A);
    probe("R9 frozen");
    do_reset();
    probe("R9 after reset");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule